// File: doc/BRIEF.md
# Pen-Down Rate-Limited Trigger Controller

This block converts a level-sensitive pen-down interrupt from a resistive touch sensor into a train of scan triggers at a reduced, programmable rate. The pen line shares circuitry with the measurement channels, so it is disturbed while a scan runs. For that reason the controller masks the pen interrupt whenever it asks for a scan. It only opens the interrupt again after a minimum number of timed polls.

After the last pen event, the controller keeps requesting scans for a bounded number of timed intervals. This lets the final position be captured after the pen lifts. It then falls back to a low-power standby state, where only a fresh pen event restarts sampling.

The scan engine is outside this block. It receives the trigger pulse, performs the conversion and returns a completion strobe together with the time the scan took, in timer ticks. The controller subtracts that time from the nominal interval, so triggers stay spaced at the interval. Timer ticks come from a prescaled clock, nominally one microsecond each.

Top module: `pen_trigger_ctrl`

## Requirements
- R1: After reset the controller is in shutdown: `irq_mask_o` is 1, `scan_trig_o` is 0 and `stray_expiry_o` is 0.
- R2: With `enable_i` high in shutdown, the controller enters standby one clock later with `irq_mask_o` = 0. With `enable_i` low, one clock later it is in shutdown with `irq_mask_o` = 1 and any running timer cancelled, so no later trigger or stray-expiry pulse results from it.
- R3: `pen_irq_i` passes through a synchroniser of `SYNC_STAGES` flops (default 2). A high synchronised level while the interrupt is unmasked, outside shutdown, is a pen event. A pen event cancels the timer, clears the poll count, raises `irq_mask_o` and gives a one-cycle `scan_trig_o` pulse, visible 3 clocks after the raw input rises with the default synchroniser. The controller then waits for scan completion.
- R4: A `scan_done_i` strobe outside shutdown loads the timer with `INTERVAL_TICKS - scan_ticks_i` ticks. Each tick is `CLK_PER_TICK` clocks, counted from the strobe.
- R5: When `scan_ticks_i` is greater than or equal to `INTERVAL_TICKS`, the timer is loaded with 1 tick.
- R6: When the timer expires while waiting for scan completion and the poll count is below `MIN_POLLS + EXTRA_POLLS`, the count is incremented and the timer restarts for a full `INTERVAL_TICKS`. If the new count is below `MIN_POLLS`, the interrupt stays masked. The next expiry then gives a scan trigger.
- R7: If the incremented count is at least `MIN_POLLS`, the interrupt is unmasked for the full interval. At that expiry it is masked again in the same clock as the scan trigger is given.
- R8: When the timer expires while waiting and the count has already reached `MIN_POLLS + EXTRA_POLLS`, no trigger is given. The controller enters standby with `irq_mask_o` = 0.
- R9: A high pen level while `irq_mask_o` is 1 gives no scan trigger.
- R10: A timer expiry in standby gives a one-cycle `stray_expiry_o` pulse and changes nothing else. In shutdown, neither the pen level nor `scan_done_i` has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Trigger generation enable |
| pen_irq_i | input | 1 | Raw, asynchronous pen-down level (high = pen down) |
| scan_done_i | input | 1 | One-cycle strobe: the requested scan has finished |
| scan_ticks_i | input | TICK_W | Duration of the finished scan in timer ticks, valid with `scan_done_i` |
| scan_trig_o | output | 1 | One-cycle scan request |
| irq_mask_o | output | 1 | 1 while the pen interrupt is masked |
| stray_expiry_o | output | 1 | One-cycle flag: timer expired in standby |

## Verification
The bench builds the controller with a 2-clock tick, a 20-tick interval and an 8-bit tick width. With these values the whole post-pen sequence fits in well under a thousand clocks: six follow-up polls, the switch from masked to unmasked polling, and the drop to standby. The 8-bit width also lets a scan time of 255, the largest value the port can carry, exercise the clamp next to the values just below and at the interval. The default two-flop synchroniser is kept, so the three-clock pen-to-trigger latency is checked exactly.

// File: rtl/pen_trig_pkg.sv
package pen_trig_pkg;

   typedef enum logic [2:0] {
      PT_OFF        = 3'd0,
      PT_IDLE       = 3'd1,
      PT_POLL       = 3'd2,
      PT_POLL_ARMED = 3'd3,
      PT_WAIT       = 3'd4
   } pt_state_e;

   // Ticks to the next poll: interval minus scan time, never below one tick.
   function automatic int unsigned pt_reload(input int unsigned interval,
                                             input int unsigned scan);
      return (scan < interval) ? (interval - scan) : 1;
   endfunction

endpackage

// File: rtl/pen_trig_sync.sv
module pen_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pen_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pen_trig_tick.sv
module pen_trig_tick #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("pen_trig_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         logic unused_in;
         assign unused_in = clr_i ^ rst_n ^ clk;
         assign tick_o    = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] pc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pc_q <= '0;
            else if (clr_i || pc_q == CW'(DIV - 1)) pc_q <= '0;
            else                                    pc_q <= pc_q + 1'b1;
         end

         assign tick_o = (pc_q == CW'(DIV - 1));

         // R4: a divided tick is never wider than one clock
         p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o && !clr_i |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/pen_trig_timer.sv
module pen_trig_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   input  logic          cancel_i,
   input  logic          tick_i,
   output logic          expire_o
);
   logic          active_q;
   logic [TW-1:0] rem_q;

   assign expire_o = active_q && tick_i && (rem_q == TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rem_q    <= '0;
      end else if (cancel_i) begin
         active_q <= 1'b0;
      end else if (load_i) begin
         active_q <= 1'b1;
         rem_q    <= load_val_i;
      end else if (active_q && tick_i) begin
         rem_q <= rem_q - 1'b1;
         if (rem_q == TW'(1)) active_q <= 1'b0;
      end
   end

   // R5: a load never leaves a zero count behind
   p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !cancel_i |=> rem_q != '0);

   // R2: a cancelled timer cannot expire in the next cycle
   p_cancel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_i |=> !expire_o);
endmodule

// File: rtl/pen_trigger_ctrl.sv
module pen_trigger_ctrl
   import pen_trig_pkg::*;
#(
   parameter int CLK_PER_TICK   = 100,
   parameter int TICK_W         = 16,
   parameter int INTERVAL_TICKS = 10000,
   parameter int MIN_POLLS      = 3,
   parameter int EXTRA_POLLS    = 3,
   parameter int SYNC_STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              pen_irq_i,
   input  logic              scan_done_i,
   input  logic [TICK_W-1:0] scan_ticks_i,
   output logic              scan_trig_o,
   output logic              irq_mask_o,
   output logic              stray_expiry_o
);
   localparam int TOTAL_POLLS = MIN_POLLS + EXTRA_POLLS;
   localparam int CNT_W       = $clog2(TOTAL_POLLS + 1);

   generate
      if (INTERVAL_TICKS < 1 || INTERVAL_TICKS >= (2 ** TICK_W)) begin : g_bad_ivl
         $error("pen_trigger_ctrl: INTERVAL_TICKS must fit in TICK_W bits");
      end
      if (MIN_POLLS < 1 || EXTRA_POLLS < 0) begin : g_bad_polls
         $error("pen_trigger_ctrl: poll counts out of range");
      end
   endgenerate

   // ---------------- pen input ----------------
   logic pen_lvl;

   pen_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pen_irq_i),
      .q_o   (pen_lvl)
   );

   // ---------------- timebase and timer ----------------
   logic              tmr_load, tmr_cancel, tmr_exp, tick;
   logic [TICK_W-1:0] tmr_val;

   pen_trig_tick #(.DIV(CLK_PER_TICK)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (tmr_load),
      .tick_o (tick)
   );

   pen_trig_timer #(.TW(TICK_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .cancel_i   (tmr_cancel),
      .tick_i     (tick),
      .expire_o   (tmr_exp)
   );

   // ---------------- control ----------------
   pt_state_e         state_q, state_d;
   logic              mask_q, mask_d;
   logic              trig_q, trig_d;
   logic              stray_q, stray_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
   logic [TICK_W-1:0] scan_reload;
   logic              pen_evt;

   assign scan_reload = TICK_W'(pt_reload(INTERVAL_TICKS, 32'(scan_ticks_i)));
   assign cnt_inc     = cnt_q + 1'b1;
   assign pen_evt     = pen_lvl && !mask_q && enable_i && (state_q != PT_OFF);

   always_comb begin
      state_d    = state_q;
      mask_d     = mask_q;
      cnt_d      = cnt_q;
      trig_d     = 1'b0;
      stray_d    = 1'b0;
      tmr_load   = 1'b0;
      tmr_cancel = 1'b0;
      tmr_val    = scan_reload;

      if (!enable_i) begin
         state_d    = PT_OFF;
         mask_d     = 1'b1;
         tmr_cancel = 1'b1;
      end else if (state_q == PT_OFF) begin
         state_d = PT_IDLE;
         mask_d  = 1'b0;
      end else if (pen_evt) begin
         tmr_cancel = 1'b1;
         cnt_d      = '0;
         mask_d     = 1'b1;
         trig_d     = 1'b1;
         state_d    = PT_WAIT;
      end else if (tmr_exp) begin
         unique case (state_q)
            PT_WAIT: begin
               if (cnt_q < CNT_W'(TOTAL_POLLS)) begin
                  cnt_d    = cnt_inc;
                  tmr_load = 1'b1;
                  tmr_val  = TICK_W'(INTERVAL_TICKS);
                  if (cnt_inc >= CNT_W'(MIN_POLLS)) begin
                     mask_d  = 1'b0;
                     state_d = PT_POLL_ARMED;
                  end else begin
                     state_d = PT_POLL;
                  end
               end else begin
                  state_d = PT_IDLE;
                  mask_d  = 1'b0;
               end
            end
            PT_POLL_ARMED: begin
               mask_d  = 1'b1;
               trig_d  = 1'b1;
               state_d = PT_WAIT;
            end
            PT_POLL: begin
               trig_d  = 1'b1;
               state_d = PT_WAIT;
            end
            PT_IDLE: stray_d = 1'b1;
            default: ;
         endcase
      end else if (scan_done_i) begin
         tmr_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PT_OFF;
         mask_q  <= 1'b1;
         cnt_q   <= '0;
         trig_q  <= 1'b0;
         stray_q <= 1'b0;
      end else begin
         state_q <= state_d;
         mask_q  <= mask_d;
         cnt_q   <= cnt_d;
         trig_q  <= trig_d;
         stray_q <= stray_d;
      end
   end

   assign scan_trig_o    = trig_q;
   assign irq_mask_o     = mask_q;
   assign stray_expiry_o = stray_q;

   // ---------------- assertions ----------------
   // R1: shutdown always keeps the interrupt masked
   p_off_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PT_OFF |-> irq_mask_o);

   // R2: dropping enable lands in shutdown, masked, with no trigger
   p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (state_q == PT_OFF) && irq_mask_o && !scan_trig_o);

   // R3: a trigger is one clock wide and the interrupt is masked with it
   p_trig_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig_o |=> !scan_trig_o);
   p_trig_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig_o |-> irq_mask_o);

   // R7: the armed poll state runs unmasked
   p_armed_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PT_POLL_ARMED |-> !irq_mask_o);

   // R8: poll count stays bounded and standby is unmasked
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(TOTAL_POLLS));
   p_idle_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PT_IDLE |-> !irq_mask_o);

   // R9: while masked, only a timer expiry may produce a trigger
   p_masked_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask_o && !tmr_exp |=> !scan_trig_o);

   // R10: the stray flag comes only from standby
   p_stray_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stray_expiry_o |-> $past(state_q) == PT_IDLE);
endmodule

// File: tb/sim_pen_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_pen_trigger_ctrl;
   localparam int P  = 2;
   localparam int IV = 20;
   localparam int TW = 8;
   localparam int MINP = 3;
   localparam int EXTP = 3;

   // scan time in ticks, expected reload in ticks (R4, R5)
   localparam int VEC [6][2] = '{
      '{0, 20}, '{5, 15}, '{19, 1}, '{20, 1}, '{27, 1}, '{255, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable_i = 1'b0;
   logic          pen_irq_i = 1'b0;
   logic          scan_done_i = 1'b0;
   logic [TW-1:0] scan_ticks_i = '0;
   logic          scan_trig_o, irq_mask_o, stray_expiry_o;

   int checks = 0;
   int errors = 0;
   int wd = 0;

   always #2.5 clk = ~clk;

   pen_trigger_ctrl #(
      .CLK_PER_TICK(P), .TICK_W(TW), .INTERVAL_TICKS(IV),
      .MIN_POLLS(MINP), .EXTRA_POLLS(EXTP), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .pen_irq_i(pen_irq_i),
      .scan_done_i(scan_done_i), .scan_ticks_i(scan_ticks_i),
      .scan_trig_o(scan_trig_o), .irq_mask_o(irq_mask_o),
      .stray_expiry_o(stray_expiry_o)
   );

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 50000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", wd);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_trig(input int maxc, output int cyc, output int prev);
      int last;
      last = irq_mask_o;
      cyc  = -1;
      prev = -1;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if (scan_trig_o) begin
            cyc  = i;
            prev = last;
            break;
         end
         last = irq_mask_o;
      end
   endtask

   task automatic scan_pulse(input int ticks);
      scan_ticks_i = TW'(ticks);
      scan_done_i  = 1'b1;
      @(negedge clk);
      scan_done_i  = 1'b0;
   endtask

   task automatic quiet(input int n, output int trigs, output int flags);
      trigs = 0;
      flags = 0;
      repeat (n) begin
         @(negedge clk);
         if (scan_trig_o)    trigs++;
         if (stray_expiry_o) flags++;
      end
   endtask

   task automatic restart();
      int c, p;
      enable_i = 1'b0;
      @(negedge clk);
      enable_i = 1'b1;
      @(negedge clk);
      pen_irq_i = 1'b1;
      wait_trig(10, c, p);
      pen_irq_i = 1'b0;
      chk("R3 restart pen trigger latency", c, 3);
   endtask

   initial begin
      int c, p, tr, fl;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 mask after reset", irq_mask_o, 1);
      chk("R1 trigger after reset", scan_trig_o, 0);
      chk("R1 stray flag after reset", stray_expiry_o, 0);

      // R10: shutdown ignores pen and scan completion
      pen_irq_i = 1'b1;
      scan_pulse(0);
      quiet(60, tr, fl);
      chk("R10 shutdown triggers", tr, 0);
      chk("R10 shutdown stray flags", fl, 0);
      chk("R10 shutdown mask", irq_mask_o, 1);
      pen_irq_i = 1'b0;
      repeat (3) @(negedge clk);

      // R2: enable opens the interrupt one clock later
      enable_i = 1'b1;
      @(negedge clk);
      chk("R2 mask after enable", irq_mask_o, 0);

      // R3: pen event latency, masking and pulse width
      pen_irq_i = 1'b1;
      wait_trig(10, c, p);
      chk("R3 pen to trigger latency", c, 3);
      chk("R3 mask with trigger", irq_mask_o, 1);
      @(negedge clk);
      chk("R3 trigger width", scan_trig_o, 0);

      // R9: pen held high while masked gives nothing
      quiet(60, tr, fl);
      chk("R9 masked pen triggers", tr, 0);
      chk("R9 mask held", irq_mask_o, 1);
      pen_irq_i = 1'b0;

      // R4, R5: reload table
      foreach (VEC[i]) begin
         restart();
         scan_pulse(VEC[i][0]);
         wait_trig(2000, c, p);
         chk($sformatf("R4 R5 gap for scan %0d", VEC[i][0]), c,
             (VEC[i][1] + IV) * P);
      end

      // R6, R7, R8: follow-up polls after one pen event
      restart();
      for (int k = 1; k <= MINP + EXTP; k++) begin
         scan_pulse(0);
         wait_trig(500, c, p);
         chk($sformatf("R6 follow-up %0d gap", k), c, 2 * IV * P);
         chk($sformatf("R7 mask before follow-up %0d", k), p, (k >= MINP) ? 0 : 1);
         chk($sformatf("R7 mask at follow-up %0d", k), irq_mask_o, 1);
      end
      scan_pulse(0);
      quiet(3 * IV * P, tr, fl);
      chk("R8 no trigger after last poll", tr, 0);
      chk("R8 mask in standby", irq_mask_o, 0);

      // R10: expiry in standby raises the stray flag only
      scan_pulse(0);
      c = 0;
      while (!stray_expiry_o && c < 500) begin
         @(negedge clk);
         c++;
      end
      chk("R10 stray flag delay", c, IV * P);
      @(negedge clk);
      chk("R10 stray flag width", stray_expiry_o, 0);
      chk("R10 mask unchanged", irq_mask_o, 0);
      quiet(20, tr, fl);
      chk("R10 no trigger from stray", tr, 0);

      // R7, R3: pen event accepted in an unmasked poll window
      restart();
      for (int k = 1; k <= MINP; k++) begin
         scan_pulse(0);
         wait_trig(500, c, p);
      end
      scan_pulse(0);
      quiet(IV * P + 2, tr, fl);
      chk("R7 unmasked poll window", irq_mask_o, 0);
      pen_irq_i = 1'b1;
      wait_trig(10, c, p);
      chk("R3 pen in armed poll latency", c, 3);
      pen_irq_i = 1'b0;

      // R2: disable cancels a running timer
      scan_pulse(0);
      quiet(5, tr, fl);
      enable_i = 1'b0;
      @(negedge clk);
      chk("R2 mask after disable", irq_mask_o, 1);
      quiet(3 * IV * P, tr, fl);
      chk("R2 no trigger after disable", tr, 0);
      enable_i = 1'b1;
      @(negedge clk);
      chk("R2 mask after re-enable", irq_mask_o, 0);
      quiet(3 * IV * P, tr, fl);
      chk("R2 cancelled timer triggers", tr, 0);
      chk("R2 cancelled timer stray flags", fl, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule